// File: doc/BRIEF.md
# Password-Gated Page Memory Command Engine

This block is the command back end of a contactless memory tag that has already been selected by its reader. An upstream receiver hands it one parsed command frame at a time: ten bytes, with the two CRC bytes removed, plus a flag saying whether the CRC was good. The engine checks the frame's card identifier and opcode, applies the access rules of a 32-page by 64-bit memory, and streams back either the contents of a page or a two-byte acknowledge/refuse reply. The CRC for the reply is appended downstream.

The rules are built from four pieces of state. A password-open flag is set by a correct password check and cleared by a wrong one. A lock field in page 0 holds one bit per page; bits can be set but never cleared. A 16-bit counter in page 2 only counts upward and stops at a terminal value. A factory serial number in page 0 can never change. Commands that write the memory hold off their reply for a programmable number of cycles to model a non-volatile write. Every refusal carries a code that names its cause.

Top module: `pgcmd_engine`

## Requirements
- R1: A frame is ignored when any of these holds: crcOk is low, tagActive is low, the low nibble of byte 0 differs from cardId, the high nibble of byte 0 is not one of the six opcodes, or cmdBusy is high. An ignored frame produces no reply and changes no state.
- R2: Frame byte k sits on frameBytes[8k+7:8k]. Byte 0 holds the card ID in bits 3:0 and the opcode in bits 7:4: read 0x4, write 0x3, lock 0x2, password check 0x6, deselect 0xA, count 0xE. The page number is bits 4:0 of byte 1 and its upper three bits are ignored, so 0xE5 means page 5. Data byte j is frame byte 2+j, and page byte j is page bits 8j+7:8j.
- R3: READ of page 0, 1 or 2 always succeeds. READ of page 3 is refused with code 0x2. READ of pages 4..31 is refused with code 0x4 while the password is closed. A successful read replies with 10 bytes: byte 0 echoed, byte 1 echoed, then the 8 page bytes from byte 0 upward. The first reply byte is valid in the cycle after the frame cycle.
- R4: WRITE checks these conditions in order. Page 0 or page 2 gives code 0x2. A closed password gives code 0x4. A set lock bit for the page gives code 0x0. Otherwise the whole page is replaced by the data. A refused write leaves memory unchanged.
- R5: LOCK with a closed password is refused with code 0x4. Otherwise it ORs data bits 63:33 into page 0 bits 63:33 and acknowledges. Page 0 bit 32+n is the lock bit of page n. Data bit 32 (page 0's lock) has no effect, and lock bits never clear.
- R6: PASSWORD CHECK compares the 64 data bits with page 3. An equal value that is not all ones acknowledges and opens access. Any other value is refused with code 0x4 and closes access.
- R7: COUNT checks these conditions in order. A closed password gives code 0x4. Lock bit 2 set gives code 0x0. A counter (page 2 bits 63:48) at or above COUNT_LIMIT (default 0x8000) gives code 0x2. Otherwise page 2 bits 47:0 take data bits 63:16 and the counter increases by exactly one.
- R8: An acknowledge is two bytes: byte 0 echoed, then 0x00. A refusal is byte 0 echoed, then {code, 4'h1}.
- R9: The reply to an accepted WRITE, LOCK or COUNT starts WRITE_CYCLES cycles later than an immediate reply. cmdBusy stays high from the accepted frame to the last reply byte, and frames offered in that window are ignored.
- R10: DESELECT always acknowledges, even at low voltage, and pulses haltReq for one cycle, visible in the cycle after the frame.
- R11: While lowVolt is high, every command other than DESELECT is refused with code 0x8 and has no effect.
- R12: After reset the password is closed and no reply is in progress. Memory is all zero except page 0 bits 31:0, which hold SERIAL.
- R13: Page 0 bits 31:0 never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; models power removal |
| tagActive | input | 1 | Tag is in the selected state |
| cardId | input | 4 | Card identifier assigned during selection |
| lowVolt | input | 1 | Supply too low for reliable writes |
| frameValid | input | 1 | One-cycle strobe: frameBytes holds a frame |
| frameBytes | input | 80 | Ten command bytes, byte 0 in the low bits |
| crcOk | input | 1 | CRC of the offered frame was correct |
| respValid | output | 1 | respByte holds a reply byte this cycle |
| respByte | output | 8 | Reply byte, first byte first |
| respLast | output | 1 | Current reply byte is the last of the reply |
| cmdBusy | output | 1 | A command is being written or answered |
| haltReq | output | 1 | One-cycle request to enter the halt state |

## Verification
If the password flag is wrong, the next READ of a high page or the next WRITE shows a 0x41 refusal where data or an acknowledge was expected, or the reverse. This appears within one command of the fault. Lock or counter state that is wrong shows up as a wrong refusal code on the following WRITE or COUNT, and as wrong bytes when page 0 or page 2 is read back. A wrong write delay shows at once in the cycle where the first reply byte appears. The bench follows every frame with a reference model and compares the reply length, the cycle of the first byte, every reply byte and the halt pulse.

// File: rtl/pgcmd_pkg.sv
package pgcmd_pkg;

  localparam int PIDX_W   = 5;
  localparam int PAGE_W   = 64;
  localparam int FRAME_W  = 80;

  // opcodes, high nibble of command byte
  localparam logic [3:0] OP_READ  = 4'h4;
  localparam logic [3:0] OP_WRITE = 4'h3;
  localparam logic [3:0] OP_LOCK  = 4'h2;
  localparam logic [3:0] OP_CHKPW = 4'h6;
  localparam logic [3:0] OP_DESEL = 4'hA;
  localparam logic [3:0] OP_COUNT = 4'hE;

  // refusal causes, high nibble of status byte
  localparam logic [3:0] ERR_LOCKED = 4'h0;
  localparam logic [3:0] ERR_RANGE  = 4'h2;
  localparam logic [3:0] ERR_PASS   = 4'h4;
  localparam logic [3:0] ERR_VOLT   = 4'h8;

  typedef struct packed {
    logic              wrPage;
    logic              wrLock;
    logic              wrCount;
    logic              pwSet;
    logic              pwClear;
    logic              loadResp;
    logic              respIsRead;
    logic [7:0]        status;
    logic [7:0]        echoCmd;
    logic [7:0]        echoAddr;
    logic [PIDX_W-1:0] page;
  } dpStrobe_t;

endpackage

// File: rtl/pgcmd_ctrl.sv
module pgcmd_ctrl
  import pgcmd_pkg::*;
#(
  parameter int          PAGES        = 32,
  parameter int          WRITE_CYCLES = 16,
  parameter logic [15:0] COUNT_LIMIT  = 16'h8000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameBytes,
  input  logic               crcOk,
  input  logic               tagActive,
  input  logic [3:0]         cardId,
  input  logic               lowVolt,
  input  logic [PAGES-1:0]   lockVec,
  input  logic [PAGE_W-1:0]  passWord,
  input  logic [15:0]        counterVal,
  input  logic               pwOpen,
  input  logic               sending,
  output dpStrobe_t          stb,
  output logic               busy,
  output logic               haltReq
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_e;

  ctrlState_e        state;
  logic [CNT_W-1:0]  waitCnt;
  logic [7:0]        pendCmd;

  logic [7:0]        cmdByte, addrByte;
  logic [3:0]        op, cid;
  logic [PIDX_W-1:0] pgIdx;
  logic [PAGE_W-1:0] dataField;
  logic              legalOp, accept;

  logic              isNack, slow, doWr, doLock, doCnt, doOpen, doClose, doHalt;
  logic [3:0]        code;

  assign cmdByte   = frameBytes[7:0];
  assign addrByte  = frameBytes[15:8];
  assign dataField = frameBytes[FRAME_W-1:16];
  assign op        = cmdByte[7:4];
  assign cid       = cmdByte[3:0];
  assign pgIdx     = addrByte[PIDX_W-1:0];

  assign legalOp = (op == OP_READ)  || (op == OP_WRITE) || (op == OP_LOCK) ||
                   (op == OP_CHKPW) || (op == OP_DESEL) || (op == OP_COUNT);

  assign accept = frameValid && crcOk && tagActive && (cid == cardId) &&
                  legalOp && (state == ST_IDLE) && !sending;

  // permission decision for the frame on the inputs
  always_comb begin
    isNack  = 1'b0;
    code    = ERR_LOCKED;
    slow    = 1'b0;
    doWr    = 1'b0;
    doLock  = 1'b0;
    doCnt   = 1'b0;
    doOpen  = 1'b0;
    doClose = 1'b0;
    doHalt  = 1'b0;
    if (op != OP_DESEL && lowVolt) begin
      isNack = 1'b1;
      code   = ERR_VOLT;
    end else begin
      case (op)
        OP_READ: begin
          if (pgIdx == PIDX_W'(3)) begin
            isNack = 1'b1;
            code   = ERR_RANGE;
          end else if (pgIdx > PIDX_W'(2) && !pwOpen) begin
            isNack = 1'b1;
            code   = ERR_PASS;
          end
        end
        OP_WRITE: begin
          if (pgIdx == PIDX_W'(0) || pgIdx == PIDX_W'(2)) begin
            isNack = 1'b1;
            code   = ERR_RANGE;
          end else if (!pwOpen) begin
            isNack = 1'b1;
            code   = ERR_PASS;
          end else if (lockVec[pgIdx]) begin
            isNack = 1'b1;
            code   = ERR_LOCKED;
          end else begin
            doWr = 1'b1;
            slow = 1'b1;
          end
        end
        OP_LOCK: begin
          if (!pwOpen) begin
            isNack = 1'b1;
            code   = ERR_PASS;
          end else begin
            doLock = 1'b1;
            slow   = 1'b1;
          end
        end
        OP_CHKPW: begin
          if ((&dataField) || (dataField != passWord)) begin
            isNack  = 1'b1;
            code    = ERR_PASS;
            doClose = 1'b1;
          end else begin
            doOpen = 1'b1;
          end
        end
        OP_COUNT: begin
          if (!pwOpen) begin
            isNack = 1'b1;
            code   = ERR_PASS;
          end else if (lockVec[2]) begin
            isNack = 1'b1;
            code   = ERR_LOCKED;
          end else if (counterVal >= COUNT_LIMIT) begin
            isNack = 1'b1;
            code   = ERR_RANGE;
          end else begin
            doCnt = 1'b1;
            slow  = 1'b1;
          end
        end
        OP_DESEL: doHalt = 1'b1;
        default: ;
      endcase
    end
  end

  // strobes towards the datapath
  always_comb begin
    stb = '0;
    if (accept) begin
      stb.wrPage     = doWr;
      stb.wrLock     = doLock;
      stb.wrCount    = doCnt;
      stb.pwSet      = doOpen;
      stb.pwClear    = doClose;
      stb.loadResp   = !slow;
      stb.respIsRead = (op == OP_READ) && !isNack;
      stb.status     = isNack ? {code, 4'h1} : 8'h00;
      stb.echoCmd    = cmdByte;
      stb.echoAddr   = addrByte;
      stb.page       = pgIdx;
    end else if (state == ST_WAIT && waitCnt == '0) begin
      stb.loadResp = 1'b1;
      stb.echoCmd  = pendCmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      pendCmd <= '0;
      haltReq <= 1'b0;
    end else begin
      haltReq <= accept && doHalt;
      case (state)
        ST_IDLE: begin
          if (accept && slow) begin
            state   <= ST_WAIT;
            waitCnt <= CNT_W'(WRITE_CYCLES - 1);
            pendCmd <= cmdByte;
          end
        end
        ST_WAIT: begin
          if (waitCnt == '0) state <= ST_IDLE;
          else waitCnt <= waitCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pgcmd_datapath.sv
module pgcmd_datapath
  import pgcmd_pkg::*;
#(
  parameter int          PAGES  = 32,
  parameter logic [31:0] SERIAL = 32'h1357_9BDF
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [PAGE_W-1:0]  frameData,
  output logic [PAGES-1:0]   lockVec,
  output logic [PAGE_W-1:0]  passWord,
  output logic [15:0]        counterVal,
  output logic [31:0]        serialVal,
  output logic               pwOpen,
  output logic               respValid,
  output logic [7:0]         respByte,
  output logic               respLast
);

  localparam int RESP_BYTES = 10;
  localparam int RIDX_W     = $clog2(RESP_BYTES + 1);
  localparam int LOCK_LO    = 33;

  logic [PAGE_W-1:0] pageQ [PAGES];

  for (genvar gp = 0; gp < PAGES; gp++) begin : g_page
    logic [PAGE_W-1:0] q;
    if (gp == 0) begin : g_ident
      always_ff @(posedge clk) begin
        if (!rstN) q <= {32'h0, SERIAL};
        else if (stb.wrLock)
          q[PAGE_W-1:LOCK_LO] <= q[PAGE_W-1:LOCK_LO] | frameData[PAGE_W-1:LOCK_LO];
      end
    end else if (gp == 2) begin : g_count
      always_ff @(posedge clk) begin
        if (!rstN) q <= '0;
        else if (stb.wrCount) q <= {q[63:48] + 16'd1, frameData[63:16]};
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN) q <= '0;
        else if (stb.wrPage && stb.page == PIDX_W'(gp)) q <= frameData;
      end
    end
    assign pageQ[gp] = q;
  end

  assign lockVec    = pageQ[0][32 +: PAGES];
  assign serialVal  = pageQ[0][31:0];
  assign passWord   = pageQ[3];
  assign counterVal = pageQ[2][63:48];

  always_ff @(posedge clk) begin
    if (!rstN) pwOpen <= 1'b0;
    else if (stb.pwSet) pwOpen <= 1'b1;
    else if (stb.pwClear) pwOpen <= 1'b0;
  end

  // reply serializer
  logic [8*RESP_BYTES-1:0] respBuf;
  logic [RIDX_W-1:0]       respLen, respIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respBuf <= '0;
      respLen <= '0;
      respIdx <= '0;
    end else if (stb.loadResp) begin
      respIdx <= '0;
      if (stb.respIsRead) begin
        respBuf <= {pageQ[stb.page], stb.echoAddr, stb.echoCmd};
        respLen <= RIDX_W'(RESP_BYTES);
      end else begin
        respBuf <= {64'h0, stb.status, stb.echoCmd};
        respLen <= RIDX_W'(2);
      end
    end else if (respIdx < respLen) begin
      respIdx <= respIdx + 1'b1;
    end
  end

  assign respValid = (respIdx < respLen);
  assign respByte  = respBuf[{respIdx, 3'b000} +: 8];
  assign respLast  = respValid && (respIdx == respLen - 1'b1);

endmodule

// File: rtl/pgcmd_engine.sv
module pgcmd_engine
  import pgcmd_pkg::*;
#(
  parameter int          PAGES        = 32,
  parameter int          WRITE_CYCLES = 16,
  parameter logic [15:0] COUNT_LIMIT  = 16'h8000,
  parameter logic [31:0] SERIAL       = 32'h1357_9BDF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tagActive,
  input  logic [3:0]  cardId,
  input  logic        lowVolt,
  input  logic        frameValid,
  input  logic [79:0] frameBytes,
  input  logic        crcOk,
  output logic        respValid,
  output logic [7:0]  respByte,
  output logic        respLast,
  output logic        cmdBusy,
  output logic        haltReq
);

  dpStrobe_t         stb;
  logic              ctrlBusy, pwOpen;
  logic [PAGES-1:0]  lockVec;
  logic [PAGE_W-1:0] passWord;
  logic [15:0]       counterVal;
  logic [31:0]       serialVal;

  pgcmd_ctrl #(
    .PAGES(PAGES), .WRITE_CYCLES(WRITE_CYCLES), .COUNT_LIMIT(COUNT_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameBytes(frameBytes),
    .crcOk(crcOk), .tagActive(tagActive), .cardId(cardId), .lowVolt(lowVolt),
    .lockVec(lockVec), .passWord(passWord), .counterVal(counterVal),
    .pwOpen(pwOpen), .sending(respValid), .stb(stb), .busy(ctrlBusy),
    .haltReq(haltReq)
  );

  pgcmd_datapath #(
    .PAGES(PAGES), .SERIAL(SERIAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .frameData(frameBytes[79:16]),
    .lockVec(lockVec), .passWord(passWord), .counterVal(counterVal),
    .serialVal(serialVal), .pwOpen(pwOpen), .respValid(respValid),
    .respByte(respByte), .respLast(respLast)
  );

  assign cmdBusy = ctrlBusy || respValid;

endmodule

// File: rtl/pgcmd_checker.sv
module pgcmd_checker #(
  parameter int          PAGES       = 32,
  parameter logic [15:0] COUNT_LIMIT = 16'h8000,
  parameter logic [31:0] SERIAL      = 32'h1357_9BDF
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameValid,
  input logic             crcOk,
  input logic             tagActive,
  input logic             pwOpen,
  input logic [PAGES-1:0] lockVec,
  input logic [15:0]      counterVal,
  input logic [31:0]      serialVal,
  input logic             haltReq
);

  // R5: lock bits only ever gain ones
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((lockVec & $past(lockVec)) == $past(lockVec)));

  // R7: the counter only steps by one and never past its limit
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (counterVal != $past(counterVal)) |->
      ((counterVal == $past(counterVal) + 16'd1) && ($past(counterVal) < COUNT_LIMIT)));

  // R13: serial number is fixed
  a_r13_serial_fixed: assert property (@(posedge clk) disable iff (!rstN)
    serialVal == SERIAL);

  // R6: access opens only as the result of a received good frame
  a_r6_open_from_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwOpen) |-> $past(frameValid && crcOk && tagActive));

  // R10: halt requests follow a frame by one cycle
  a_r10_halt_from_frame: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> $past(frameValid && crcOk && tagActive));

endmodule

bind pgcmd_engine pgcmd_checker #(
  .PAGES(PAGES), .COUNT_LIMIT(COUNT_LIMIT), .SERIAL(SERIAL)
) u_chk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .crcOk(crcOk),
  .tagActive(tagActive), .pwOpen(pwOpen), .lockVec(lockVec),
  .counterVal(counterVal), .serialVal(serialVal), .haltReq(haltReq)
);

// File: tb/tb_pgcmd_engine.sv
module tb_pgcmd_engine;

  localparam int          WC     = 6;
  localparam logic [15:0] LIMIT  = 16'd4;
  localparam logic [31:0] SER    = 32'hA5C3_1E77;
  localparam logic [3:0]  CID    = 4'h9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tagActive = 1'b1;
  logic [3:0]  cardId = CID;
  logic        lowVolt = 1'b0;
  logic        frameValid = 1'b0;
  logic [79:0] frameBytes = '0;
  logic        crcOk = 1'b1;
  logic        respValid, respLast, cmdBusy, haltReq;
  logic [7:0]  respByte;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pgcmd_engine #(
    .PAGES(32), .WRITE_CYCLES(WC), .COUNT_LIMIT(LIMIT), .SERIAL(SER)
  ) dut (
    .clk(clk), .rstN(rstN), .tagActive(tagActive), .cardId(cardId),
    .lowVolt(lowVolt), .frameValid(frameValid), .frameBytes(frameBytes),
    .crcOk(crcOk), .respValid(respValid), .respByte(respByte),
    .respLast(respLast), .cmdBusy(cmdBusy), .haltReq(haltReq)
  );

  // reference model state
  logic [63:0] mMem [32];
  bit          mPw;

  function automatic bit legalOp(input logic [3:0] op);
    return op == 4'h4 || op == 4'h3 || op == 4'h2 || op == 4'h6 ||
           op == 4'hA || op == 4'hE;
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'h4: return "R3";
      4'h3: return "R4";
      4'h2: return "R5";
      4'h6: return "R6";
      4'hE: return "R7";
      4'hA: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [3:0] cid,
                       input logic [7:0] addr, input logic [63:0] d,
                       input bit crcG, input bit act, input bit lv,
                       output int eLen, output int eLat,
                       output logic [79:0] eBuf, output bit eHalt);
    logic [4:0]  pg;
    bit          nack, slow;
    logic [3:0]  code;
    logic [15:0] cnt;
    eLen = 0; eLat = 0; eBuf = '0; eHalt = 0;
    if (!crcG || !act || cid != CID || !legalOp(op)) return;
    pg = addr[4:0]; nack = 0; slow = 0; code = 4'h0;
    if (op != 4'hA && lv) begin nack = 1; code = 4'h8; end
    else begin
      case (op)
        4'h4: if (pg == 3) begin nack = 1; code = 4'h2; end
              else if (pg > 2 && !mPw) begin nack = 1; code = 4'h4; end
        4'h3: if (pg == 0 || pg == 2) begin nack = 1; code = 4'h2; end
              else if (!mPw) begin nack = 1; code = 4'h4; end
              else if (mMem[0][32+pg]) begin nack = 1; code = 4'h0; end
              else begin mMem[pg] = d; slow = 1; end
        4'h2: if (!mPw) begin nack = 1; code = 4'h4; end
              else begin mMem[0][63:33] = mMem[0][63:33] | d[63:33]; slow = 1; end
        4'h6: if (d == '1 || d != mMem[3]) begin nack = 1; code = 4'h4; mPw = 0; end
              else mPw = 1;
        4'hE: if (!mPw) begin nack = 1; code = 4'h4; end
              else if (mMem[0][34]) begin nack = 1; code = 4'h0; end
              else if (mMem[2][63:48] >= LIMIT) begin nack = 1; code = 4'h2; end
              else begin
                cnt = mMem[2][63:48] + 16'd1;
                mMem[2] = {cnt, d[63:16]};
                slow = 1;
              end
        default: eHalt = 1;
      endcase
    end
    eLat = slow ? WC + 1 : 1;
    if (op == 4'h4 && !nack) begin
      eLen = 10; eBuf = {mMem[pg], addr, op, cid};
    end else begin
      eLen = 2; eBuf = {64'h0, (nack ? {code, 4'h1} : 8'h00), op, cid};
    end
  endtask

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // send one frame, collect the reply, compare with the model
  task automatic doCmd(input string req, input logic [3:0] op, input logic [3:0] cid,
                       input logic [7:0] addr, input logic [63:0] d,
                       input bit crcG, input bit act, input bit lv, input bit intrude);
    int eLen, eLat, aLen, lat;
    logic [79:0] eBuf, aBuf, mask;
    bit eHalt, aHalt;
    model(op, cid, addr, d, crcG, act, lv, eLen, eLat, eBuf, eHalt);
    @(negedge clk);
    frameBytes = {d, addr, op, cid};
    crcOk = crcG; tagActive = act; lowVolt = lv; frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
    lat = 1;
    aHalt = haltReq;
    while (!respValid && lat < WC + 8) begin
      if (intrude && lat == 3) begin
        check(cmdBusy === 1'b1, "R9", $sformatf("cmdBusy=%0b expected 1 during write", cmdBusy));
        frameBytes = {64'h0BAD_0BAD_0BAD_0BAD, 8'h00, 4'h6, CID};
        crcOk = 1'b1; tagActive = 1'b1; lowVolt = 1'b0; frameValid = 1'b1;
      end
      @(negedge clk);
      frameValid = 1'b0;
      lat++;
    end
    aLen = 0; aBuf = '0;
    if (respValid) begin
      while (aLen < 12) begin
        aBuf[aLen*8 +: 8] = respByte;
        aLen++;
        if (respLast) break;
        @(negedge clk);
      end
      @(negedge clk);
    end
    lowVolt = 1'b0; tagActive = 1'b1; crcOk = 1'b1;
    mask = (eLen == 10) ? '1 : 80'hFFFF;
    check(aLen == eLen && (eLen == 0 || (lat == eLat && (aBuf & mask) == (eBuf & mask)))
          && aHalt == eHalt, req,
          $sformatf("op %h: len %0d lat %0d data %h halt %0b, expected len %0d lat %0d data %h halt %0b",
                    op, aLen, lat, aBuf, aHalt, eLen, eLat, eBuf, eHalt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0]  op, cid;
    logic [7:0]  addr;
    logic [63:0] d;
    bit          crcG, act, lv;
    void'($urandom(32'd7741));
    for (int i = 0; i < 32; i++) mMem[i] = '0;
    mMem[0][31:0] = SER;
    mPw = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: idle after reset
    check(respValid === 1'b0 && cmdBusy === 1'b0 && haltReq === 1'b0, "R12",
          $sformatf("valid=%0b busy=%0b halt=%0b expected 0 0 0", respValid, cmdBusy, haltReq));

    doCmd("R12", 4'h4, CID, 8'h00, '0, 1, 1, 0, 0);          // serial readable
    doCmd("R3",  4'h4, CID, 8'h05, '0, 1, 1, 0, 0);          // closed -> 0x41
    doCmd("R3",  4'h4, CID, 8'h03, '0, 1, 1, 0, 0);          // page 3 -> 0x21
    doCmd("R4",  4'h3, CID, 8'h05, 64'h1122, 1, 1, 0, 0);    // closed -> 0x41
    doCmd("R6",  4'h6, CID, 8'h00, '1, 1, 1, 0, 0);          // all ones refused
    doCmd("R6",  4'h6, CID, 8'h00, '0, 1, 1, 0, 0);          // match opens
    doCmd("R2",  4'h3, CID, 8'hE5, 64'hDEAD_BEEF_0123_4567, 1, 1, 0, 0);
    doCmd("R2",  4'h4, CID, 8'h25, '0, 1, 1, 0, 0);
    doCmd("R4",  4'h3, CID, 8'h02, 64'h55, 1, 1, 0, 0);       // page 2 -> 0x21
    doCmd("R4",  4'h3, CID, 8'h00, 64'h55, 1, 1, 0, 0);       // page 0 -> 0x21
    doCmd("R5",  4'h2, CID, 8'h00, 64'h0000_0021_0000_0000, 1, 1, 0, 0); // page 5 + bit 0
    doCmd("R5",  4'h3, CID, 8'h05, 64'h77, 1, 1, 0, 0);       // locked -> 0x01
    doCmd("R5",  4'h4, CID, 8'h00, '0, 1, 1, 0, 0);
    doCmd("R8",  4'h3, CID, 8'hFF, 64'hA0A0_B1B1_C2C2_D3D3, 1, 1, 0, 0);
    doCmd("R8",  4'h4, CID, 8'h1F, '0, 1, 1, 0, 0);
    for (int k = 0; k <= int'(LIMIT); k++)
      doCmd("R7", 4'hE, CID, 8'h00, 64'hFEDC_BA98_7654_3210 + 64'(k), 1, 1, 0, 0);
    doCmd("R7",  4'h4, CID, 8'h02, '0, 1, 1, 0, 0);
    doCmd("R1",  4'h4, 4'h3, 8'h00, '0, 1, 1, 0, 0);          // wrong id
    doCmd("R1",  4'h3, CID, 8'h06, 64'h99, 0, 1, 0, 0);       // bad crc
    doCmd("R1",  4'h3, CID, 8'h06, 64'h99, 1, 0, 0, 0);       // not active
    doCmd("R1",  4'h7, CID, 8'h06, 64'h99, 1, 1, 0, 0);       // undefined opcode
    doCmd("R1",  4'h4, CID, 8'h06, '0, 1, 1, 0, 0);           // page 6 still zero
    doCmd("R11", 4'h4, CID, 8'h00, '0, 1, 1, 1, 0);
    doCmd("R11", 4'h3, CID, 8'h07, 64'h42, 1, 1, 1, 0);
    doCmd("R11", 4'h4, CID, 8'h07, '0, 1, 1, 0, 0);
    doCmd("R10", 4'hA, CID, 8'h00, '0, 1, 1, 1, 0);
    doCmd("R10", 4'hA, CID, 8'h00, '0, 1, 1, 0, 0);
    doCmd("R9",  4'h3, CID, 8'h08, 64'h8888_7777, 1, 1, 0, 1); // intruder ignored
    doCmd("R9",  4'h4, CID, 8'h08, '0, 1, 1, 0, 0);            // still open
    doCmd("R6",  4'h6, CID, 8'h00, 64'h1, 1, 1, 0, 0);         // wrong closes
    doCmd("R6",  4'h4, CID, 8'h08, '0, 1, 1, 0, 0);
    doCmd("R6",  4'h6, CID, 8'h00, '0, 1, 1, 0, 0);
    doCmd("R7",  4'h2, CID, 8'h00, 64'h0000_0004_0000_0000, 1, 1, 0, 0); // lock page 2
    doCmd("R7",  4'hE, CID, 8'h00, 64'h1234, 1, 1, 0, 0);      // locked -> 0x01

    for (int n = 0; n < 300; n++) begin
      case ($urandom_range(0, 13))
        0, 1, 2, 3: op = 4'h4;
        4, 5, 6:    op = 4'h3;
        7:          op = 4'h2;
        8, 9:       op = 4'h6;
        10:         op = 4'hE;
        11:         op = 4'hA;
        default:    op = 4'($urandom_range(0, 15));
      endcase
      cid  = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : CID;
      addr = 8'($urandom_range(0, 255));
      d    = {32'($urandom), 32'($urandom)};
      if (op == 4'h6 && $urandom_range(0, 1) == 1) d = mMem[3];
      if (op == 4'h2) d = 64'h1 << (33 + $urandom_range(0, 30));
      if (op == 4'h3 && addr[4:0] == 5'd3 && $urandom_range(0, 1) == 1) d = 64'h0;
      crcG = ($urandom_range(0, 11) != 0);
      act  = ($urandom_range(0, 15) != 0);
      lv   = ($urandom_range(0, 19) == 0);
      doCmd(reqOf(op), op, cid, addr, d, crcG, act, lv, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule